// File: doc/BRIEF.md
# Ring-Wrapping Remote DMA Port

This block is the host-facing remote DMA port of a network controller's packet memory. The host sets a start address and a byte count through small byte-wide control registers. It then reads or writes a data port over and over. Each data-port access moves one, two or four bytes between the host and an internal packet RAM. After each access the address moves forward and the count goes down. When the address reaches the end of the receive ring, it jumps back to the start of the ring.

When the count runs out, a completion status bit is set. The block drives a masked interrupt line from its status register. Accesses that fall outside the valid memory regions read back as all ones and their write data is dropped. Once the count is zero, further data-port traffic has no effect.

Control registers (4-bit offset, 8-bit data): 0 command, 1 address low byte, 2 address high byte, 3 count low byte, 4 count high byte, 5 ring first page, 6 ring end page (the address of the first byte past the ring, divided by 256), 7 configuration, 8 status (write 1 to clear), 9 interrupt mask.

Top module: `rdma_port`

## Requirements
- R1: The data port moves 2 bytes per access when configuration bit 0 is 1 and 1 byte otherwise. The long port always moves 4 bytes. Memory bytes map little-endian onto the data bus: the lowest address is bits 7:0. Read lanes beyond the access width return zero.
- R2: After each accepted access the address rises by the access width. If the result equals the ring end page times 256, the address is reloaded with the ring first page times 256.
- R3: If the remaining count is at most the access width, the count becomes 0 and status bit 6 (transfer done) is set. Otherwise the count drops by the width.
- R4: While the count is zero, data-port and long-port reads and writes change nothing: address, count, status, memory and the read-data output all keep their values.
- R5: The irq output is high exactly when (status AND mask AND 0x7F) is nonzero. Status bit 7 (reset flag) therefore never raises irq. Bit 7 is cleared by any command write whose bit 0 (halt) is 0.
- R6: A command write with halt at 0, bit 3 (remote read) or bit 4 (remote write) at 1, and a count of zero sets status bit 6 on the next cycle. The same write with halt at 1 does not.
- R7: Word and long accesses clear address bit 0 before reaching memory. The address then advances from its unaligned value.
- R8: The valid memory is bytes 0 to 31 and the packet window of 1024 bytes from 0x0400. Any byte outside these regions reads as 0xFF and ignores writes.
- R9: The 16-bit count is loaded as two bytes. A write to one byte changes only that half.
- R10: Writing 1 to a status bit clears it. If a set and a clear of the same bit happen in one cycle, the set wins.
- R11: After reset the address is 0, the count is 0, status is 0x80, the mask is 0, configuration is 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Control register write strobe |
| regAddr | input | 4 | Control register offset |
| regWrData | input | 8 | Control register write data |
| portRd | input | 1 | Data-port read strobe (1 or 2 bytes) |
| portWr | input | 1 | Data-port write strobe (1 or 2 bytes) |
| longRd | input | 1 | Long-port read strobe (4 bytes) |
| longWr | input | 1 | Long-port write strobe (4 bytes) |
| hostWrData | input | 32 | Write data, low lanes used for narrow accesses |
| hostRdData | output | 32 | Read data, updated one cycle after an accepted read |
| dmaAddr | output | 16 | Current remote address |
| dmaCount | output | 16 | Remaining byte count |
| status | output | 8 | Status register |
| irq | output | 1 | Masked interrupt request |

## Verification
Assertions check the following on every cycle:
- an accepted access always lowers a nonzero count;
- a stepped address never lands on the ring end;
- nothing moves while the count is zero;
- a done event always leaves the done bit set, even against a clear in the same cycle;
- the reset flag alone never raises irq.

Other behaviours can only be shown by the bench's scenarios:
- the actual data values and byte lanes;
- the wrap target;
- all-ones reads outside the valid regions;
- the zero-count command flag and its suppression by halt;
- loading the count one byte at a time.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

  typedef enum logic [1:0] {
    W_BYTE = 2'd0,
    W_WORD = 2'd1,
    W_LONG = 2'd2
  } width_e;

  typedef struct packed {
    logic       ldAddrLo;
    logic       ldAddrHi;
    logic       ldCntLo;
    logic       ldCntHi;
    logic [7:0] ldVal;
    logic       step;
    logic       memWr;
    width_e     width;
  } rdma_strobe_t;

  localparam logic [3:0] REG_CMD     = 4'd0;
  localparam logic [3:0] REG_ADDR_LO = 4'd1;
  localparam logic [3:0] REG_ADDR_HI = 4'd2;
  localparam logic [3:0] REG_CNT_LO  = 4'd3;
  localparam logic [3:0] REG_CNT_HI  = 4'd4;
  localparam logic [3:0] REG_RING_LO = 4'd5;
  localparam logic [3:0] REG_RING_HI = 4'd6;
  localparam logic [3:0] REG_CFG     = 4'd7;
  localparam logic [3:0] REG_STATUS  = 4'd8;
  localparam logic [3:0] REG_MASK    = 4'd9;

  localparam int DONE_BIT  = 6;
  localparam int RESET_BIT = 7;

endpackage

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
  import rdma_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWr,
  input  logic [3:0]        regAddr,
  input  logic [7:0]        regWrData,
  input  logic              portRd,
  input  logic              portWr,
  input  logic              longRd,
  input  logic              longWr,
  input  logic              countZero,
  input  logic              dmaDone,
  output rdma_strobe_t      stb,
  output logic [ADDR_W-1:0] ringFirstAddr,
  output logic [ADDR_W-1:0] ringEndAddr,
  output logic [7:0]        statusQ,
  output logic              irq
);

  localparam int PAGE_W = ADDR_W - 8;

  logic [PAGE_W-1:0] ringFirstPg, ringEndPg;
  logic              wordMode;
  logic [6:0]        maskQ;
  logic              accessReq, cmdWr, cmdRun, zeroFlag;
  logic [7:0]        setVec, clrVec;

  assign accessReq = portRd | portWr | longRd | longWr;
  assign cmdWr     = regWr && (regAddr == REG_CMD);
  assign cmdRun    = cmdWr && !regWrData[0];
  assign zeroFlag  = cmdRun && (regWrData[3] || regWrData[4]) && countZero;

  always_comb begin
    stb          = '0;
    stb.ldAddrLo = regWr && (regAddr == REG_ADDR_LO);
    stb.ldAddrHi = regWr && (regAddr == REG_ADDR_HI);
    stb.ldCntLo  = regWr && (regAddr == REG_CNT_LO);
    stb.ldCntHi  = regWr && (regAddr == REG_CNT_HI);
    stb.ldVal    = regWrData;
    stb.step     = accessReq && !countZero;
    stb.memWr    = portWr | longWr;
    if (longRd || longWr)  stb.width = W_LONG;
    else if (wordMode)     stb.width = W_WORD;
    else                   stb.width = W_BYTE;
  end

  always_comb begin
    setVec = '0;
    clrVec = '0;
    setVec[DONE_BIT] = dmaDone | zeroFlag;
    if (regWr && (regAddr == REG_STATUS)) clrVec = regWrData;
    if (cmdRun) clrVec[RESET_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ringFirstPg <= '0;
      ringEndPg   <= '0;
      wordMode    <= 1'b0;
      maskQ       <= '0;
      statusQ     <= 8'h80;
    end else begin
      if (regWr && regAddr == REG_RING_LO) ringFirstPg <= regWrData[PAGE_W-1:0];
      if (regWr && regAddr == REG_RING_HI) ringEndPg   <= regWrData[PAGE_W-1:0];
      if (regWr && regAddr == REG_CFG)     wordMode    <= regWrData[0];
      if (regWr && regAddr == REG_MASK)    maskQ       <= regWrData[6:0];
      statusQ <= (statusQ & ~clrVec) | setVec;
    end
  end

  assign ringFirstAddr = {ringFirstPg, 8'h00};
  assign ringEndAddr   = {ringEndPg, 8'h00};
  assign irq           = |(statusQ[6:0] & maskQ);

  // R5: the reset flag alone never raises the interrupt line
  assert_flag_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (statusQ[6:0] == 7'd0) |-> !irq);

  // R5: a running command always drops the reset flag
  assert_flag_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmdRun |=> !statusQ[RESET_BIT]);

  // R10: completion from the datapath survives a same-cycle clear
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dmaDone |=> statusQ[DONE_BIT]);

endmodule

// File: rtl/rdma_datapath.sv
module rdma_datapath
  import rdma_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16,
  parameter int LOW_BYTES  = 32,
  parameter int PMEM_BASE  = 'h0400,
  parameter int PMEM_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rdma_strobe_t      stb,
  input  logic [ADDR_W-1:0] ringFirstAddr,
  input  logic [ADDR_W-1:0] ringEndAddr,
  input  logic [31:0]       hostWrData,
  output logic [ADDR_W-1:0] addrQ,
  output logic [CNT_W-1:0]  cntQ,
  output logic              countZero,
  output logic              dmaDone,
  output logic [31:0]       rdDataQ
);

  localparam int MEM_BYTES = LOW_BYTES + PMEM_BYTES;
  localparam int IDX_W     = $clog2(MEM_BYTES);
  localparam int LANES     = 4;
  localparam logic [ADDR_W-1:0] LOW_END = ADDR_W'(LOW_BYTES);
  localparam logic [ADDR_W-1:0] WIN_LO  = ADDR_W'(PMEM_BASE);
  localparam logic [ADDR_W-1:0] WIN_HI  = ADDR_W'(PMEM_BASE + PMEM_BYTES);

  logic [7:0] mem [MEM_BYTES];

  logic [ADDR_W-1:0] stepA, sumAddr, nextAddr, baseAddr;
  logic [CNT_W-1:0]  stepC;
  logic [2:0]        nBytes;
  logic              anyLoad;
  logic [LANES-1:0]  laneOn, laneOk;
  logic [IDX_W-1:0]  laneIdx [LANES];
  logic [31:0]       rdComb;

  always_comb begin
    unique case (stb.width)
      W_WORD:  nBytes = 3'd2;
      W_LONG:  nBytes = 3'd4;
      default: nBytes = 3'd1;
    endcase
  end

  assign stepA     = ADDR_W'(nBytes);
  assign stepC     = CNT_W'(nBytes);
  assign sumAddr   = addrQ + stepA;
  assign nextAddr  = (sumAddr == ringEndAddr) ? ringFirstAddr : sumAddr;
  assign countZero = (cntQ == '0);
  assign dmaDone   = stb.step && (cntQ <= stepC);
  assign anyLoad   = stb.ldAddrLo | stb.ldAddrHi | stb.ldCntLo | stb.ldCntHi;
  assign baseAddr  = (stb.width == W_BYTE) ? addrQ : {addrQ[ADDR_W-1:1], 1'b0};

  function automatic logic inRegion(input logic [ADDR_W-1:0] a);
    return (a < LOW_END) || ((a >= WIN_LO) && (a < WIN_HI));
  endfunction

  function automatic logic [IDX_W-1:0] toIdx(input logic [ADDR_W-1:0] a);
    if (a < LOW_END) return IDX_W'(a);
    return IDX_W'(a - WIN_LO + LOW_END);
  endfunction

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [ADDR_W-1:0] laneAddr;
    assign laneAddr    = baseAddr + ADDR_W'(k);
    assign laneOn[k]   = (3'(k) < nBytes);
    assign laneOk[k]   = inRegion(laneAddr);
    assign laneIdx[k]  = toIdx(laneAddr);
    assign rdComb[8*k +: 8] = !laneOn[k] ? 8'h00 :
                              (laneOk[k] ? mem[laneIdx[k]] : 8'hFF);
  end

  always_ff @(posedge clk) begin
    if (stb.step && stb.memWr) begin
      for (int k = 0; k < LANES; k++) begin
        if (laneOn[k] && laneOk[k]) mem[laneIdx[k]] <= hostWrData[8*k +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrQ   <= '0;
      cntQ    <= '0;
      rdDataQ <= '0;
    end else begin
      if (anyLoad) begin
        if (stb.ldAddrLo) addrQ[7:0]        <= stb.ldVal;
        if (stb.ldAddrHi) addrQ[ADDR_W-1:8] <= stb.ldVal[ADDR_W-9:0];
        if (stb.ldCntLo)  cntQ[7:0]         <= stb.ldVal;
        if (stb.ldCntHi)  cntQ[CNT_W-1:8]   <= stb.ldVal[CNT_W-9:0];
      end else if (stb.step) begin
        addrQ <= nextAddr;
        cntQ  <= dmaDone ? '0 : cntQ - stepC;
      end
      if (stb.step && !stb.memWr) rdDataQ <= rdComb;
    end
  end

  // R4: the control side only steps while a count remains
  assert_step_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stb.step |-> !countZero);

  // R4: an exhausted transfer holds address and count
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (countZero && !anyLoad) |=> (countZero && $stable(addrQ)));

  // R3: every accepted access shrinks the count
  assert_count_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.step && !anyLoad) |=> (cntQ < $past(cntQ)));

  // R2: a stepped address never rests on the ring end
  assert_ring_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.step && !anyLoad && ringFirstAddr != ringEndAddr) |=> (addrQ != $past(ringEndAddr)));

endmodule

// File: rtl/rdma_port.sv
module rdma_port
  import rdma_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16,
  parameter int LOW_BYTES  = 32,
  parameter int PMEM_BASE  = 'h0400,
  parameter int PMEM_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWr,
  input  logic [3:0]        regAddr,
  input  logic [7:0]        regWrData,
  input  logic              portRd,
  input  logic              portWr,
  input  logic              longRd,
  input  logic              longWr,
  input  logic [31:0]       hostWrData,
  output logic [31:0]       hostRdData,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [CNT_W-1:0]  dmaCount,
  output logic [7:0]        status,
  output logic              irq
);

  rdma_strobe_t      stb;
  logic [ADDR_W-1:0] ringFirstAddr, ringEndAddr;
  logic              countZero, dmaDone;

  rdma_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
    .portRd(portRd), .portWr(portWr), .longRd(longRd), .longWr(longWr),
    .countZero(countZero), .dmaDone(dmaDone), .stb(stb),
    .ringFirstAddr(ringFirstAddr), .ringEndAddr(ringEndAddr),
    .statusQ(status), .irq(irq)
  );

  rdma_datapath #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LOW_BYTES(LOW_BYTES),
    .PMEM_BASE(PMEM_BASE), .PMEM_BYTES(PMEM_BYTES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .ringFirstAddr(ringFirstAddr), .ringEndAddr(ringEndAddr),
    .hostWrData(hostWrData), .addrQ(dmaAddr), .cntQ(dmaCount),
    .countZero(countZero), .dmaDone(dmaDone), .rdDataQ(hostRdData)
  );

endmodule

// File: tb/rdma_port_tb.sv
module rdma_port_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWr = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic        portRd = 1'b0, portWr = 1'b0, longRd = 1'b0, longWr = 1'b0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic [15:0] dmaAddr, dmaCount;
  logic [7:0]  status;
  logic        irq;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  always #5 clk = ~clk;

  rdma_port u_dut (
    .clk(clk), .rst_n(rst_n), .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
    .portRd(portRd), .portWr(portWr), .longRd(longRd), .longWr(longWr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .dmaAddr(dmaAddr),
    .dmaCount(dmaCount), .status(status), .irq(irq)
  );

  localparam logic [3:0] OP_REG = 4'd1, OP_SET = 4'd2, OP_BW = 4'd3, OP_BR = 4'd4,
                         OP_LW = 4'd5, OP_LR = 4'd6, OP_CA = 4'd7, OP_CC = 4'd8,
                         OP_CS = 4'd9, OP_CI = 4'd10;

  // entry = {op, register offset, data or expected value, requirement number}
  localparam int NVEC = 62;
  localparam logic [47:0] VEC [NVEC] = '{
    {OP_REG, 4'd9, 32'h000000FF, 8'd5},  // mask all
    {OP_CS,  4'd0, 32'h00000080, 8'd5},  // R5 reset flag present
    {OP_CI,  4'd0, 32'h00000000, 8'd5},  // R5 bit 7 never interrupts
    {OP_REG, 4'd0, 32'h00000000, 8'd5},  // run clears flag
    {OP_CS,  4'd0, 32'h00000000, 8'd5},
    {OP_REG, 4'd5, 32'h00000004, 8'd2},  // ring 0x0400..0x05FF
    {OP_REG, 4'd6, 32'h00000006, 8'd2},
    {OP_SET, 4'd0, 32'h05FE0003, 8'd2},
    {OP_REG, 4'd0, 32'h00000010, 8'd6},  // R6 nonzero count: no flag
    {OP_CS,  4'd0, 32'h00000000, 8'd6},
    {OP_BW,  4'd0, 32'h000000A1, 8'd1},
    {OP_CA,  4'd0, 32'h000005FF, 8'd1},  // R1 byte step
    {OP_BW,  4'd0, 32'h000000A2, 8'd2},
    {OP_CA,  4'd0, 32'h00000400, 8'd2},  // R2 wrap
    {OP_CC,  4'd0, 32'h00000001, 8'd3},
    {OP_BW,  4'd0, 32'h000000A3, 8'd3},
    {OP_CA,  4'd0, 32'h00000401, 8'd2},
    {OP_CC,  4'd0, 32'h00000000, 8'd3},  // R3
    {OP_CS,  4'd0, 32'h00000040, 8'd3},
    {OP_CI,  4'd0, 32'h00000001, 8'd5},
    {OP_REG, 4'd9, 32'h00000000, 8'd5},
    {OP_CI,  4'd0, 32'h00000000, 8'd5},  // R5 masked off
    {OP_REG, 4'd9, 32'h000000FF, 8'd5},
    {OP_REG, 4'd8, 32'h00000040, 8'd10},
    {OP_CS,  4'd0, 32'h00000000, 8'd10}, // R10 W1C
    {OP_BW,  4'd0, 32'h00000055, 8'd4},  // R4 ignored write
    {OP_CA,  4'd0, 32'h00000401, 8'd4},
    {OP_CC,  4'd0, 32'h00000000, 8'd4},
    {OP_CS,  4'd0, 32'h00000000, 8'd4},
    {OP_SET, 4'd0, 32'h05FE0003, 8'd2},
    {OP_BR,  4'd0, 32'h000000A1, 8'd1},
    {OP_BR,  4'd0, 32'h000000A2, 8'd2},
    {OP_BR,  4'd0, 32'h000000A3, 8'd2},  // read across the wrap
    {OP_BR,  4'd0, 32'h000000A3, 8'd4},  // R4 ignored read holds data
    {OP_REG, 4'd8, 32'h00000040, 8'd10},
    {OP_REG, 4'd7, 32'h00000001, 8'd1},  // word mode
    {OP_SET, 4'd0, 32'h04100005, 8'd1},
    {OP_BW,  4'd0, 32'h0000BEEF, 8'd1},
    {OP_CA,  4'd0, 32'h00000412, 8'd1},
    {OP_CC,  4'd0, 32'h00000003, 8'd1},
    {OP_BW,  4'd0, 32'h00001234, 8'd1},
    {OP_BW,  4'd0, 32'h00005678, 8'd3},  // 1 left, width 2
    {OP_CC,  4'd0, 32'h00000000, 8'd3},
    {OP_CA,  4'd0, 32'h00000416, 8'd1},
    {OP_CS,  4'd0, 32'h00000040, 8'd3},
    {OP_REG, 4'd8, 32'h00000040, 8'd10},
    {OP_SET, 4'd0, 32'h04110004, 8'd7},  // R7 odd start
    {OP_BR,  4'd0, 32'h0000BEEF, 8'd7},
    {OP_CA,  4'd0, 32'h00000413, 8'd7},
    {OP_BR,  4'd0, 32'h00001234, 8'd7},
    {OP_SET, 4'd0, 32'h04200008, 8'd1},
    {OP_LW,  4'd0, 32'hDEADBEEF, 8'd1},
    {OP_CC,  4'd0, 32'h00000004, 8'd1},  // long ignores word mode
    {OP_LW,  4'd0, 32'h01020304, 8'd1},
    {OP_CA,  4'd0, 32'h00000428, 8'd1},
    {OP_SET, 4'd0, 32'h04200006, 8'd3},
    {OP_LR,  4'd0, 32'hDEADBEEF, 8'd1},
    {OP_CC,  4'd0, 32'h00000002, 8'd3},
    {OP_LR,  4'd0, 32'h01020304, 8'd3},  // 2 left, width 4
    {OP_CC,  4'd0, 32'h00000000, 8'd3},
    {OP_CS,  4'd0, 32'h00000040, 8'd3},
    {OP_REG, 4'd8, 32'h00000040, 8'd10}
  };

  task automatic check(input int rq, input logic [31:0] got, input logic [31:0] exp);
    testCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL R%0d: actual %h expected %h", rq, got, exp);
    end
  endtask

  task automatic pulseReg(input logic [3:0] a, input logic [7:0] d);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic doOp(input logic [3:0] op, input logic [3:0] ra,
                      input logic [31:0] d, input int rq);
    case (op)
      OP_REG: pulseReg(ra, d[7:0]);
      OP_SET: begin
        pulseReg(4'd1, d[23:16]); pulseReg(4'd2, d[31:24]);
        pulseReg(4'd3, d[7:0]);   pulseReg(4'd4, d[15:8]);
      end
      OP_BW: begin hostWrData = d; portWr = 1'b1; @(negedge clk); portWr = 1'b0; end
      OP_LW: begin hostWrData = d; longWr = 1'b1; @(negedge clk); longWr = 1'b0; end
      OP_BR: begin portRd = 1'b1; @(negedge clk); portRd = 1'b0; check(rq, hostRdData, d); end
      OP_LR: begin longRd = 1'b1; @(negedge clk); longRd = 1'b0; check(rq, hostRdData, d); end
      OP_CA: check(rq, {16'h0, dmaAddr}, d);
      OP_CC: check(rq, {16'h0, dmaCount}, d);
      OP_CS: check(rq, {24'h0, status}, d);
      OP_CI: check(rq, {31'h0, irq}, d);
      default: ;
    endcase
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    check(11, {16'h0, dmaAddr}, 32'h0);
    check(11, {16'h0, dmaCount}, 32'h0);
    check(11, {24'h0, status}, 32'h80);
    check(11, {31'h0, irq}, 32'h0);

    for (int i = 0; i < NVEC; i++)
      doOp(VEC[i][47:44], VEC[i][43:40], VEC[i][39:8], int'(VEC[i][7:0]));

    // R8 outside the valid regions, byte mode
    doOp(OP_REG, 4'd7, 32'h0, 8);
    doOp(OP_SET, 4'd0, 32'h01000001, 8);
    doOp(OP_BW,  4'd0, 32'h00000077, 8);
    doOp(OP_SET, 4'd0, 32'h01000001, 8);
    doOp(OP_BR,  4'd0, 32'h000000FF, 8);
    doOp(OP_SET, 4'd0, 32'h01000004, 8);
    doOp(OP_LR,  4'd0, 32'hFFFFFFFF, 8);
    // R8 low region holds data
    doOp(OP_SET, 4'd0, 32'h00050001, 8);
    doOp(OP_BW,  4'd0, 32'h0000003C, 8);
    doOp(OP_SET, 4'd0, 32'h00050001, 8);
    doOp(OP_BR,  4'd0, 32'h0000003C, 8);
    doOp(OP_REG, 4'd8, 32'h40, 10);

    // R6 zero-count command, halted then running
    doOp(OP_REG, 4'd0, 32'h09, 6);
    doOp(OP_CS,  4'd0, 32'h00, 6);
    doOp(OP_REG, 4'd0, 32'h08, 6);
    doOp(OP_CS,  4'd0, 32'h40, 6);
    doOp(OP_REG, 4'd8, 32'h40, 10);

    // R9 count halves
    doOp(OP_REG, 4'd3, 32'h34, 9);
    doOp(OP_REG, 4'd4, 32'h12, 9);
    doOp(OP_CC,  4'd0, 32'h1234, 9);
    doOp(OP_REG, 4'd3, 32'h56, 9);
    doOp(OP_CC,  4'd0, 32'h1256, 9);

    // R10 done and clear in the same cycle: set wins
    doOp(OP_SET, 4'd0, 32'h04300001, 10);
    hostWrData = 32'h11; portWr = 1'b1;
    regWr = 1'b1; regAddr = 4'd8; regWrData = 8'h40;
    @(negedge clk);
    portWr = 1'b0; regWr = 1'b0;
    doOp(OP_CS,  4'd0, 32'h40, 10);
    doOp(OP_REG, 4'd8, 32'h40, 10);
    doOp(OP_CS,  4'd0, 32'h00, 10);

    // R11 second reset after activity
    doOp(OP_REG, 4'd9, 32'hFF, 11);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check(11, {24'h0, status}, 32'h80);
    check(11, {31'h0, irq}, 32'h0);
    check(11, {16'h0, dmaAddr}, 32'h0);
    finish();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish();
    end
  end

endmodule